// File: doc/BRIEF.md
# Bit-Serial Maximum Selector

This block finds which of several input streams holds the largest unsigned word, with no magnitude comparators. Every stream delivers one bit per clock. All streams advance together, most significant bit first. The block keeps one "still in the running" flag per stream. On each bit cycle a single OR across the surviving streams tells whether any survivor shows a 1. If so, every survivor showing a 0 is knocked out. If not, nobody changes. Once the last bit has passed, the surviving flags mark exactly the streams that carry the maximum. The lowest-numbered survivor is reported as the winning index.

A start strobe opens a pass and fills all flags. The next `WORD_BITS` cycles each take one bit from every stream. A one-clock valid pulse follows the last bit. One result therefore comes every `WORD_BITS + 1` clocks when passes are run back to back. The index and the mask stay where they are until the next start. The cost of the selection logic grows linearly with the number of streams: one flag, one AND term and one OR input per stream.

Top module: `bitser_max_top`

## Requirements
- R1: After reset, and before any start, `done_o` is 0, `cand_o` is all ones and `max_idx_o` is 0.
- R2: A clock edge with `start_i` high sets every bit of `cand_o` to 1. The `bits_i` value on that edge is ignored. The next `WORD_BITS` edges each take one bit per stream, MSB first.
- R3: On a bit edge where at least one surviving stream presents a 1, each survivor presenting 0 is cleared, and each survivor presenting 1 stays set.
- R4: On a bit edge where no surviving stream presents a 1, the candidate mask does not change.
- R5: A cleared candidate stays cleared until the next start.
- R6: After the `WORD_BITS`-th bit edge, bit i of `cand_o` is 1 exactly when stream i holds the largest value, so ties leave several bits set. At least one bit is always set.
- R7: `max_idx_o` is the index of the lowest-numbered set bit of `cand_o`.
- R8: `done_o` is 1 for exactly the one clock that follows the edge that took the `WORD_BITS`-th bit. Back-to-back passes give one result every `WORD_BITS + 1` clocks.
- R9: Outside a pass, `bits_i` has no effect. `cand_o` and `max_idx_o` hold until the next start, and `done_o` stays 0.
- R10: A start during a pass abandons that pass and begins a new one, and no `done_o` pulse is produced for the abandoned pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Opens a new pass and fills all candidate flags |
| bits_i | input | N_STREAMS | Current bit of every stream; bit i belongs to stream i |
| max_idx_o | output | $clog2(N_STREAMS) | Lowest-numbered surviving stream |
| cand_o | output | N_STREAMS | Surviving-candidate mask |
| done_o | output | 1 | One-clock pulse after the last bit of a pass |

## Verification
The start edge counts as cycle 0. Bit j, counted from the MSB, is taken at edge j+1. The mask, the index and `done_o` are therefore due right after edge `WORD_BITS`, and they stay valid until the next start is sampled. The bench changes inputs on the falling edge and reads outputs just before it drives the next values. Every check therefore sees the state left by a known number of rising edges: intermediate masks one edge after each bit, the valid pulse after the last bit, and its absence one edge later. Idle and restart cases read the mask and the index through the outputs, after the ignored stimulus and before the next start.

// File: rtl/bitser_max_pkg.sv
package bitser_max_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_SCAN = 1'b1
  } seq_state_e;

  function automatic int unsigned idx_width(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/bitser_max_seq.sv
module bitser_max_seq
  import bitser_max_pkg::*;
#(
  parameter int unsigned WORD_BITS = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic take_o,
  output logic done_o
);

  localparam int unsigned CNT_W = (WORD_BITS > 1) ? $clog2(WORD_BITS) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_BITS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             cnt_en;

  assign take_o = (state_q == SEQ_SCAN) && !start_i;
  assign cnt_en = start_i || (state_q == SEQ_SCAN);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    done_d  = 1'b0;
    if (start_i) begin
      state_d = SEQ_SCAN;
      cnt_d   = '0;
    end else if (state_q == SEQ_SCAN) begin
      if (cnt_q == LAST_BIT) begin
        state_d = SEQ_IDLE;
        cnt_d   = '0;
        done_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else if (cnt_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
    end
  end

  assign done_o = done_q;

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q); // R8

  AST_START_KILLS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_q); // R10

  AST_IDLE_NO_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SEQ_IDLE && !start_i) |=> !done_q); // R9

endmodule

// File: rtl/bitser_max_anyone.sv
module bitser_max_anyone #(
  parameter int unsigned N_STREAMS = 16
) (
  input  logic [N_STREAMS-1:0] cand_i,
  input  logic [N_STREAMS-1:0] bits_i,
  output logic                 any_one_o
);

  logic [N_STREAMS-1:0] hit;

  for (genvar g = 0; g < N_STREAMS; g++) begin : g_hit
    assign hit[g] = cand_i[g] & bits_i[g];
  end

  assign any_one_o = |hit;

endmodule

// File: rtl/bitser_max_cells.sv
module bitser_max_cells #(
  parameter int unsigned N_STREAMS = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 take_i,
  input  logic                 any_one_i,
  input  logic [N_STREAMS-1:0] bits_i,
  output logic [N_STREAMS-1:0] cand_o
);

  logic [N_STREAMS-1:0] cand_q, cand_d;
  logic                 cell_en;

  assign cell_en = start_i || take_i;

  for (genvar g = 0; g < N_STREAMS; g++) begin : g_cell
    always_comb begin
      if (start_i) begin
        cand_d[g] = 1'b1;
      end else begin
        cand_d[g] = cand_q[g] & (bits_i[g] | ~any_one_i);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cand_q[g] <= 1'b1;
      end else if (cell_en) begin
        cand_q[g] <= cand_d[g];
      end
    end

    AST_NO_REVIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_i && !cand_q[g]) |=> !cand_q[g]); // R5

    AST_ONE_SURVIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (take_i && cand_q[g] && bits_i[g]) |=> cand_q[g]); // R3
  end

  assign cand_o = cand_q;

  AST_START_FILLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (&cand_q)); // R2

  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !start_i && ((cand_q & bits_i) == '0)) |=> $stable(cand_q)); // R4

endmodule

// File: rtl/bitser_max_lowenc.sv
module bitser_max_lowenc #(
  parameter int unsigned N_STREAMS = 16,
  parameter int unsigned IDX_W     = 4
) (
  input  logic [N_STREAMS-1:0] req_i,
  output logic [IDX_W-1:0]     idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N_STREAMS - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/bitser_max_top.sv
module bitser_max_top
  import bitser_max_pkg::*;
#(
  parameter int unsigned N_STREAMS = 16,
  parameter int unsigned WORD_BITS = 8,
  localparam int unsigned IDX_W    = idx_width(N_STREAMS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [N_STREAMS-1:0] bits_i,
  output logic [IDX_W-1:0]     max_idx_o,
  output logic [N_STREAMS-1:0] cand_o,
  output logic                 done_o
);

  logic                 take;
  logic                 any_one;
  logic [N_STREAMS-1:0] cand;

  bitser_max_seq #(
    .WORD_BITS(WORD_BITS)
  ) i_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .take_o (take),
    .done_o (done_o)
  );

  bitser_max_anyone #(
    .N_STREAMS(N_STREAMS)
  ) i_anyone (
    .cand_i   (cand),
    .bits_i   (bits_i),
    .any_one_o(any_one)
  );

  bitser_max_cells #(
    .N_STREAMS(N_STREAMS)
  ) i_cells (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .take_i   (take),
    .any_one_i(any_one),
    .bits_i   (bits_i),
    .cand_o   (cand)
  );

  bitser_max_lowenc #(
    .N_STREAMS(N_STREAMS),
    .IDX_W    (IDX_W)
  ) i_lowenc (
    .req_i(cand),
    .idx_o(max_idx_o)
  );

  assign cand_o = cand;

  AST_SURVIVOR_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand != '0); // R6

  AST_IDX_IS_CAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand[max_idx_o]); // R7

  for (genvar g = 0; g < N_STREAMS; g++) begin : g_lowchk
    AST_IDX_LOWEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cand[g] |-> (max_idx_o <= IDX_W'(g))); // R7
  end

  AST_IDLE_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !take) |=> ($stable(cand) && $stable(max_idx_o))); // R9

endmodule

// File: tb/test_bitser_max_top.sv
`timescale 1ns/1ps
module test_bitser_max_top;

  localparam int N = 16;
  localparam int K = 8;
  localparam int IW = 4;

  typedef struct packed {
    logic [7:0] fill;
    logic [3:0] a_idx;
    logic [7:0] a_val;
    logic [3:0] b_idx;
    logic [7:0] b_val;
    logic [3:0] exp_idx;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{8'h10, 4'd5,  8'h80, 4'd9,  8'h7F, 4'd5},
    '{8'h00, 4'd3,  8'h01, 4'd12, 8'h01, 4'd3},
    '{8'hFF, 4'd0,  8'hFF, 4'd1,  8'hFF, 4'd0},
    '{8'h00, 4'd15, 8'h00, 4'd15, 8'h00, 4'd0},
    '{8'h55, 4'd14, 8'hAA, 4'd2,  8'hAB, 4'd2},
    '{8'h80, 4'd7,  8'h7F, 4'd10, 8'h81, 4'd10},
    '{8'h01, 4'd15, 8'hF0, 4'd4,  8'h0F, 4'd15}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [N-1:0]  bits = '0;
  logic [IW-1:0] max_idx;
  logic [N-1:0]  cand;
  logic          done;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] words [N];

  always #2 clk = ~clk;

  bitser_max_top #(.N_STREAMS(N), .WORD_BITS(K)) i_bitser_max_top (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .bits_i(bits),
    .max_idx_o(max_idx), .cand_o(cand), .done_o(done)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] ref_mask();
    logic [7:0] mx = 8'h00;
    logic [N-1:0] m = '0;
    for (int i = 0; i < N; i++) if (words[i] > mx) mx = words[i];
    for (int i = 0; i < N; i++) m[i] = (words[i] == mx);
    return m;
  endfunction

  function automatic logic [N-1:0] column(input int b);
    logic [N-1:0] c;
    for (int i = 0; i < N; i++) c[i] = words[i][b];
    return c;
  endfunction

  // At a negedge: raise start; returns at the negedge after the start edge.
  task automatic open_pass(input logic [N-1:0] junk);
    start = 1'b1;
    bits  = junk;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Feeds all K bits; returns at the negedge right after the K-th bit edge.
  task automatic feed_bits();
    for (int b = K - 1; b >= 0; b--) begin
      bits = column(b);
      @(negedge clk);
    end
  endtask

  task automatic load_vec(input vec_t v);
    for (int i = 0; i < N; i++) words[i] = v.fill;
    words[v.a_idx] = v.a_val;
    words[v.b_idx] = v.b_val;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    logic [N-1:0] keep_mask;
    logic [IW-1:0] keep_idx;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(done == 1'b0, "R1 done", done, 0);
    check(cand == '1, "R1 cand", cand, 16'hFFFF);
    check(max_idx == '0, "R1 idx", max_idx, 0);
    rst_n = 1'b1;
    @(negedge clk);
    bits = 16'hA5A5;
    @(negedge clk);
    check(cand == '1, "R9 idle before start", cand, 16'hFFFF);

    // Table walk: R6, R7, R8
    foreach (VECS[v]) begin
      load_vec(VECS[v]);
      open_pass(16'h0000);
      check(cand == '1, "R2 fill", cand, 16'hFFFF);
      feed_bits();
      check(done == 1'b1, "R8 done pulse", done, 1);
      check(cand == ref_mask(), "R6 mask", cand, ref_mask());
      check(max_idx == VECS[v].exp_idx, "R7 index", max_idx, VECS[v].exp_idx);
      bits = ~column(0);
      @(negedge clk);
      check(done == 1'b0, "R8 pulse ends", done, 0);
    end

    // R3 intermediate drop, R2 start-cycle bits ignored
    for (int i = 0; i < N; i++) words[i] = 8'h3C;
    words[2] = 8'h80;
    words[6] = 8'hC0;
    open_pass(16'h0000);
    bits = column(K - 1);
    @(negedge clk);
    check(cand == 16'h0044, "R3 drop on first bit", cand, 16'h0044);
    bits = column(K - 2);
    @(negedge clk);
    check(cand == 16'h0040, "R3 second bit", cand, 16'h0040);
    for (int b = K - 3; b >= 0; b--) begin
      bits = column(b);
      @(negedge clk);
    end
    check(done && max_idx == 4'd6, "R3 result idx", max_idx, 6);

    // R4 quiet bit keeps mask; R5 cleared stays cleared
    for (int i = 0; i < N; i++) words[i] = 8'h11;
    words[9] = 8'h40;
    open_pass(16'hFFFF);
    bits = column(K - 1);
    @(negedge clk);
    check(cand == 16'hFFFF, "R4 all-zero bit keeps mask", cand, 16'hFFFF);
    bits = column(K - 2);
    @(negedge clk);
    check(cand == 16'h0200, "R3 drop to stream 9", cand, 16'h0200);
    bits = 16'h0000;
    @(negedge clk);
    check(cand == 16'h0200, "R4 quiet after drop", cand, 16'h0200);
    bits = 16'hFFFF;
    @(negedge clk);
    check(cand == 16'h0200, "R5 no revive", cand, 16'h0200);
    for (int b = K - 5; b >= 0; b--) begin
      bits = 16'hFFFF;
      @(negedge clk);
    end
    check(done && cand == 16'h0200 && max_idx == 4'd9, "R5 final", cand, 16'h0200);

    // R9 idle: bits ignored, outputs hold
    keep_mask = cand;
    keep_idx  = max_idx;
    for (int c = 0; c < 5; c++) begin
      bits = (c % 2 == 0) ? 16'h0000 : 16'hFFFF;
      @(negedge clk);
    end
    check(cand == keep_mask, "R9 mask held", cand, keep_mask);
    check(max_idx == keep_idx, "R9 idx held", max_idx, keep_idx);
    check(done == 1'b0, "R9 no done", done, 0);

    // R10 restart mid-pass
    for (int i = 0; i < N; i++) words[i] = 8'h00;
    words[1] = 8'hFF;
    open_pass(16'h0000);
    bits = column(K - 1);
    @(negedge clk);
    bits = column(K - 2);
    @(negedge clk);
    check(cand == 16'h0002, "R10 before restart", cand, 16'h0002);
    for (int i = 0; i < N; i++) words[i] = 8'h20;
    words[13] = 8'h21;
    open_pass(16'hFFFF);
    check(cand == '1 && done == 1'b0, "R10 restart fill", cand, 16'hFFFF);
    for (int b = K - 1; b >= 1; b--) begin
      bits = column(b);
      @(negedge clk);
      check(done == 1'b0, "R10 no early done", done, 0);
    end
    bits = column(0);
    @(negedge clk);
    check(done && max_idx == 4'd13, "R10 restart result", max_idx, 13);

    // R8 back-to-back: result every K+1 clocks
    for (int p = 0; p < 3; p++) begin
      for (int i = 0; i < N; i++) words[i] = 8'(i);
      words[p * 4 + 1] = 8'hEE;
      open_pass(16'h0000);
      feed_bits();
      check(done == 1'b1, "R8 back-to-back done", done, 1);
      check(max_idx == IW'(p * 4 + 1), "R8 back-to-back idx", max_idx, p * 4 + 1);
    end
    bits = '0;
    @(negedge clk);
    check(done == 1'b0, "R8 final pulse ends", done, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule